// File: doc/BRIEF.md
# Masked XOR Scan-Out Compactor

This block sits between the internal scan chains of a core and its scan-out pins. Every shift cycle it folds the last bit of each chain into a smaller set of compacted output bits through XOR trees. A chain can hold an unknown value that would corrupt the compacted result. To keep such a value away from the output, a per-chain mask bit forces that chain to logic 0 before it reaches the XOR trees.

The mask bits sit in a shift register that the tester fills one bit per clock, through a serial input, during a mask-load phase. A scan enable and a mask-load enable separate this phase from scan shifting. The block also gives the chains their shift permission. That permission is withheld whenever the mask is loading, so chain shifting and mask loading never take place in the same cycle.

Top module: `xmask_compactor`

## Requirements
- R1: While reset is low, and after it, every mask bit is 0, so all chains take part in compaction until a mask is loaded. The reset is asynchronous and active low.
- R2: With no chain masked, compacted bit k equals the XOR of the chain bits whose index i satisfies i mod OUTS = k. With defaults: out0 = c0^c2^c4^c6 and out1 = c1^c3^c5^c7. The compactor is combinational, so an output follows a change on the chain bits within the same cycle.
- R3: A chain whose mask bit is 1 contributes 0 to its XOR tree. Changing the value of a masked chain has no effect on any compacted bit.
- R4: In each cycle with mask_ld_en high, the mask shifts by one place on the rising clock edge. mask_si enters the bit for chain 0, and the bit for chain i moves to chain i+1. After CHAINS load cycles, the first bit supplied masks chain CHAINS-1.
- R5: In a cycle with mask_ld_en low, the mask holds its value, whatever scan_en and mask_si do.
- R6: When mask_ld_en is low, shift_gate equals scan_en.
- R7: When mask_ld_en is high, shift_gate is 0 even if scan_en is high, and the mask still loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mask register |
| rst_n | input | 1 | Asynchronous active-low reset; clears the mask |
| scan_en | input | 1 | Requests scan shifting of the chains |
| mask_ld_en | input | 1 | Selects the mask-load phase; has priority over scan_en |
| mask_si | input | 1 | Serial mask bit shifted in during mask load |
| chain_out | input | CHAINS | Last bit of each internal scan chain |
| comp_out | output | OUTS | Compacted scan-out bits |
| shift_gate | output | 1 | Shift permission for the chains; low during mask load |

## Verification
The bench builds the block with its defaults of eight chains and two compacted bits, which places four chains on each XOR tree. That is enough to use one-hot chain patterns to show each chain's mapping to its tree and to read back every mask bit. It is also enough to confirm the shift order, because a loaded pattern lands in reversed positions. Toggling masked chains while unmasked ones stay fixed shows the gating. Asserting both enables together exercises the priority rule while the mask keeps shifting.

// File: rtl/xmask_compactor.sv
module xmask_compactor #(
  parameter int CHAINS = 8,
  parameter int OUTS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scan_en,
  input  logic              mask_ld_en,
  input  logic              mask_si,
  input  logic [CHAINS-1:0] chain_out,
  output logic [OUTS-1:0]   comp_out,
  output logic              shift_gate
);

  logic [CHAINS-1:0] mask_q;
  logic [CHAINS-1:0] kept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (mask_ld_en) mask_q <= {mask_q[CHAINS-2:0], mask_si};
  end

  assign kept       = chain_out & ~mask_q;
  assign shift_gate = scan_en & ~mask_ld_en;

  for (genvar k = 0; k < OUTS; k++) begin : g_tree
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int j = k; j < CHAINS; j += OUTS) acc = acc ^ kept[j];
    end
    assign comp_out[k] = acc;
  end

  // R4
  mask_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_ld_en |=> mask_q[0] == $past(mask_si));

  // R4
  mask_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_ld_en |=> mask_q[CHAINS-1:1] == $past(mask_q[CHAINS-2:0]));

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_ld_en |=> $stable(mask_q));

  // R3
  all_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> comp_out == '0);

  // R7
  no_shift_in_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_ld_en |-> !shift_gate);

endmodule

// File: tb/xmask_compactor_bench.sv
module xmask_compactor_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scan_en = 1'b0;
  logic       mask_ld_en = 1'b0;
  logic       mask_si = 1'b0;
  logic [7:0] chain_out = '0;
  logic [1:0] comp_out;
  logic       shift_gate;

  always #2 clk = ~clk;

  xmask_compactor #(.CHAINS(8), .OUTS(2)) u_xmask_compactor (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .mask_ld_en(mask_ld_en),
    .mask_si(mask_si), .chain_out(chain_out), .comp_out(comp_out),
    .shift_gate(shift_gate)
  );

  typedef struct {
    logic [1:0] comp;
    logic       sh;
    string      req;
  } exp_t;

  exp_t       q[$];
  int         checks = 0;
  int         fails = 0;
  logic [7:0] bm = '0;
  bit         done = 1'b0;

  function automatic logic [1:0] model(input logic [7:0] c, input logic [7:0] m);
    logic [1:0] r;
    r = '0;
    for (int j = 0; j < 8; j++) r[j % 2] = r[j % 2] ^ (c[j] & ~m[j]);
    return r;
  endfunction

  task automatic step(input logic s, input logic l, input logic si,
                      input logic [7:0] c, input string req);
    exp_t e;
    @(negedge clk);
    scan_en = s; mask_ld_en = l; mask_si = si; chain_out = c;
    e.comp = model(c, bm);
    e.sh   = s & ~l;
    e.req  = req;
    q.push_back(e);
    if (l && rst_n) bm = {bm[6:0], si};
  endtask

  task automatic load_mask(input logic [7:0] m, input logic s, input string req);
    for (int i = 7; i >= 0; i--) step(s, 1'b1, m[i], 8'h00, req);
  endtask

  task automatic probe(input string req);
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, 8'h01 << i, req);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (comp_out !== e.comp || shift_gate !== e.sh) begin
          fails++;
          $display("FAIL %s: comp_out=%b shift_gate=%b expected comp_out=%b shift_gate=%b",
                   e.req, comp_out, shift_gate, e.comp, e.sh);
        end
      end
    end
  end

  initial begin : watchdog
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (2) @(posedge clk);
    // R1: reset state, nothing masked; the load is ignored while in reset
    step(1'b0, 1'b1, 1'b1, 8'hFF, "R1");
    step(1'b0, 1'b0, 1'b0, 8'h01, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 8'h80, "R1");
    // R2: mapping of each chain onto its tree, unmasked
    probe("R2");
    step(1'b1, 1'b0, 1'b0, 8'h55, "R2");
    step(1'b1, 1'b0, 1'b0, 8'hAA, "R2");
    step(1'b1, 1'b0, 1'b0, 8'h37, "R2");
    step(1'b1, 1'b0, 1'b0, 8'hFF, "R2");
    // R4: serial load order, read back through one-hot probes
    load_mask(8'b1100_1010, 1'b0, "R4");
    probe("R4");
    // R3: masked chains toggled, unmasked chains held
    step(1'b1, 1'b0, 1'b0, 8'h35, "R3");
    step(1'b1, 1'b0, 1'b0, 8'h35 | 8'hCA, "R3");
    step(1'b1, 1'b0, 1'b0, 8'h35 & ~8'h0A, "R3");
    step(1'b1, 1'b0, 1'b0, 8'hFF, "R3");
    // R5: mask holds while not loading, with mask_si toggling
    for (int i = 0; i < 6; i++) step(i[0], 1'b0, ~i[0], 8'h00, "R5");
    probe("R5");
    // R6: shift_gate follows scan_en while not loading
    step(1'b0, 1'b0, 1'b0, 8'h0F, "R6");
    step(1'b1, 1'b0, 1'b1, 8'hF0, "R6");
    // R7: both enables high, loading wins and still shifts
    load_mask(8'b0011_0101, 1'b1, "R7");
    probe("R7");
    // R4: partial load shifts the existing mask upward
    step(1'b0, 1'b1, 1'b1, 8'h00, "R4");
    step(1'b0, 1'b1, 1'b0, 8'h00, "R4");
    step(1'b0, 1'b1, 1'b1, 8'h00, "R4");
    probe("R4");
    // R3: fully masked gives zero for any chain values
    load_mask(8'hFF, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b0, 8'hA5, "R3");
    step(1'b1, 1'b0, 1'b0, 8'h5A, "R3");
    step(1'b0, 1'b0, 1'b0, 8'h00, "R6");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule